// File: doc/BRIEF.md
# UART Receiver with Wake-on-Break

This block receives asynchronous serial words on a single RX line. A baud tick at sixteen times the bit rate drives it. A low level on the idle line begins a start bit, which is confirmed at mid-bit. Eight data bits are then taken least significant bit first, followed by one stop bit. Each finished word enters a two-entry receive buffer, together with a flag that marks a bad stop bit. The host sees the oldest word at the read port and removes it with a one-cycle read strobe.

For low-power systems the host can arm a wake-up detector. While it is armed, word reception is suspended and the block only watches the line. The first falling edge raises the receive interrupt, which stays up until the host issues a read strobe. The detector disarms itself at the next rising edge of the line, and normal reception then resumes. The RX line passes through a two-flop synchronizer before anything else looks at it.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, irq_o, overrun_o and wake_en_o are 0.
- R2: A frame is one low start bit, 8 data bits sent LSB first, and a high stop bit, each 16 baud ticks long. Each bit is sampled at the middle of the bit. A received word appears on rd_data_o as the oldest unread entry.
- R3: A start bit that reads high at its mid-bit sample, 8 ticks after the line first went low, is discarded, and no word is stored.
- R4: rd_ferr_o is 1 for a word whose stop bit was sampled low and 0 for a word whose stop bit was sampled high. The flag travels through the buffer with its word.
- R5: irq_o is 1 whenever the buffer holds at least one unread word. A pulse on rd_i removes the oldest word. A read of an empty buffer removes nothing.
- R6: The buffer holds 2 words. A third complete word that arrives while the buffer is full, with no read in the same cycle, is dropped and sets overrun_o. While overrun_o is 1, no word is stored. overrun_o clears while rx_en_i is 0.
- R7: While rx_en_i is 0, no word is received.
- R8: A pulse on wake_arm_i sets wake_en_o. While wake_en_o is 1, no word is received, even when a whole frame or a long low break is on the line.
- R9: While wake_en_o is 1, a high-to-low transition of the line raises irq_o. irq_o stays 1 until a pulse on rd_i.
- R10: wake_en_o returns to 0 on the first low-to-high transition of the line after the wake-up transition. After that, frames are received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en_i | input | 1 | Receive enable; low also clears overrun |
| wake_arm_i | input | 1 | Pulse that arms the wake-up detector |
| rd_i | input | 1 | Read strobe: pops the oldest word and clears the wake interrupt |
| rd_data_o | output | 8 | Oldest unread word |
| rd_ferr_o | output | 1 | Framing-error flag of the oldest unread word |
| irq_o | output | 1 | Receive interrupt |
| overrun_o | output | 1 | Overrun error |
| wake_en_o | output | 1 | Wake-up detector armed |

## Verification
The hardest case to reach is the wake-up exit. It needs a falling edge while the detector is armed, then a read strobe while the line is still low, then a rising edge. Only in that order can the bench show that the interrupt came from the wake event and not from a stored word. The stimulus holds a break far longer than a frame, reads once in the middle of the break to prove that nothing was stored, and then releases the line. Overrun is reached by sending three frames back to back with no reads and then a fourth frame. The bench then drains the buffer to show that only the first two words survived. A behavioural model that runs on every clock follows the line through synchronizer latency and tick pacing, and it also runs with a slower tick rate.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} uwr_state_e;

  function automatic logic edge_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic edge_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  function automatic int unsigned mid_tick(input int unsigned ovs);
    return ovs / 2 - 1;
  endfunction
endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame
  import uwr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID   = CW'(mid_tick(OVS));
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  uwr_state_e        state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (!en_i) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!rx_i) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (tick_i) begin
          if (cnt == MID) begin
            state <= rx_i ? ST_IDLE : ST_DATA;
            cnt   <= '0;
            bitn  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (cnt == LAST) begin
            shreg <= {rx_i, shreg[DATA_W-1:1]};
            cnt   <= '0;
            if (bitn == BLAST) state <= ST_STOP;
            else               bitn  <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: if (tick_i) begin
          if (cnt == LAST) state <= ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign done_o = en_i && (state == ST_STOP) && tick_i && (cnt == LAST);
  assign data_o = shreg;
  assign ferr_o = ~rx_i;
endmodule

// File: rtl/uwr_fifo.sv
module uwr_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       drop_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i && (level_o != '0);
  assign push_ok = push_i && ((level_o != LW'(DEPTH)) || pop_ok);
  assign drop_o  = push_i && !push_ok;
  assign dout_o  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_ok) begin
        mem[wptr] <= din_i;
        wptr      <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      end
      if (pop_ok) rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      level_o <= level_o + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uwr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              baud_tick_i,
  input  logic              rx_en_i,
  input  logic              wake_arm_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ferr_o,
  output logic              irq_o,
  output logic              overrun_o,
  output logic              wake_en_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic              rx_s, rx_q, rx_fall, rx_rise;
  logic              wake_seen, wake_flag, wake_evt, wake_done;
  logic              frm_en, word_done, word_ferr, word_drop;
  logic [DATA_W-1:0] word_data;
  logic [DATA_W:0]   head;
  logic [LW-1:0]     fifo_level;

  uwr_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_s;
  end

  assign rx_fall   = edge_fall(rx_q, rx_s);
  assign rx_rise   = edge_rise(rx_q, rx_s);
  assign wake_evt  = wake_en_o && rx_fall;
  assign wake_done = wake_en_o && wake_seen && rx_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en_o <= 1'b0;
      wake_seen <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      wake_en_o <= wake_arm_i || (wake_en_o && !wake_done);
      wake_seen <= wake_en_o && !wake_done && (wake_seen || rx_fall);
      wake_flag <= wake_evt || (wake_flag && !rd_i);
    end
  end

  assign frm_en = rx_en_i && !wake_en_o && !overrun_o;

  uwr_frame #(.DATA_W(DATA_W), .OVS(OVS)) frame_i (
    .clk(clk), .rst_n(rst_n), .en_i(frm_en), .tick_i(baud_tick_i),
    .rx_i(rx_s), .done_o(word_done), .data_o(word_data), .ferr_o(word_ferr)
  );

  uwr_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_i(word_done),
    .din_i({word_ferr, word_data}), .pop_i(rd_i),
    .dout_o(head), .level_o(fifo_level), .drop_o(word_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun_o <= 1'b0;
    else if (!rx_en_i) overrun_o <= 1'b0;
    else if (word_drop) overrun_o <= 1'b1;
  end

  assign rd_data_o = head[DATA_W-1:0];
  assign rd_ferr_o = head[DATA_W];
  assign irq_o     = (fifo_level != '0) || wake_flag;
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk #(
  parameter int DEPTH = 2,
  parameter int LW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_i,
  input logic          rd_i,
  input logic          irq_o,
  input logic          overrun_o,
  input logic          wake_en_o,
  input logic          rx_fall,
  input logic          rx_rise,
  input logic          word_done,
  input logic          word_drop,
  input logic [LW-1:0] fifo_level
);
  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(word_drop));

  p_ovr_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> !word_done);

  p_irq_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0) |-> irq_o);

  p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> !word_done);

  p_wake_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en_o |-> !word_done);

  p_wake_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en_o && rx_fall) |=> irq_o);

  p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_i && fifo_level == '0) |=> irq_o);

  p_wake_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_en_o) |-> $past(rx_rise));
endmodule

bind uart_wake_rx uwr_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .rd_i(rd_i),
  .irq_o(irq_o), .overrun_o(overrun_o), .wake_en_o(wake_en_o),
  .rx_fall(rx_fall), .rx_rise(rx_rise), .word_done(word_done),
  .word_drop(word_drop), .fifo_level(fifo_level)
);

// File: tb/uart_wake_rx_tb_top.sv
`timescale 1ns/1ps
module uart_wake_rx_tb_top;
  localparam int DEPTH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b0, rx_en = 1'b1, arm = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_ferr, irq, ovr, wake_en;

  int tests = 0, fails = 0, td = 1, tcnt = 0;
  bit run = 1'b0;

  always #2.5 clk = ~clk;

  uart_wake_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_tick_i(tick), .rx_en_i(rx_en),
    .wake_arm_i(arm), .rd_i(rd), .rd_data_o(rd_data), .rd_ferr_o(rd_ferr),
    .irq_o(irq), .overrun_o(ovr), .wake_en_o(wake_en)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= td) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  // behavioural reference model
  logic [8:0] mq[$];
  logic m_s1, m_s2, m_prev, m_wake, m_seen, m_wflag, m_ovr;
  int m_ph, m_cnt, m_bits;
  logic [7:0] m_sh;

  always @(posedge clk) begin
    logic o_s2, o_prev, fall, rise, active, done, ferr, pop, clr, o_wake, o_seen;
    if (!rst_n) begin
      mq.delete();
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_wake = 0; m_seen = 0; m_wflag = 0;
      m_ovr = 0; m_ph = 0; m_cnt = 0; m_bits = 0; m_sh = 0;
    end else begin
      o_s2 = m_s2; o_prev = m_prev; o_wake = m_wake; o_seen = m_seen;
      fall = o_prev && !o_s2;
      rise = !o_prev && o_s2;
      active = rx_en && !m_wake && !m_ovr;
      done = 0; ferr = 0;
      if (!active) begin
        m_ph = 0; m_cnt = 0;
      end else if (m_ph == 0) begin
        if (!o_s2) begin m_ph = 1; m_cnt = 0; end
      end else if (tick) begin
        if (m_ph == 1) begin
          if (m_cnt == 7) begin m_ph = o_s2 ? 0 : 2; m_cnt = 0; m_bits = 0; end
          else m_cnt++;
        end else if (m_ph == 2) begin
          if (m_cnt == 15) begin
            m_sh = {o_s2, m_sh[7:1]}; m_cnt = 0;
            if (m_bits == 7) m_ph = 3; else m_bits++;
          end else m_cnt++;
        end else begin
          if (m_cnt == 15) begin done = 1; ferr = !o_s2; m_ph = 0; end
          else m_cnt++;
        end
      end
      pop = rd && (mq.size() > 0);
      if (pop) void'(mq.pop_front());
      if (!rx_en) m_ovr = 0;
      else if (done && mq.size() >= DEPTH) m_ovr = 1;
      if (done && mq.size() < DEPTH) mq.push_back({ferr, m_sh});
      clr = o_wake && o_seen && rise;
      m_wflag = (o_wake && fall) || (m_wflag && !rd);
      m_seen = o_wake && !clr && (o_seen || fall);
      m_wake = arm || (o_wake && !clr);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = rx;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      check(irq == ((mq.size() > 0) || m_wflag), "R5 model irq", irq, (mq.size() > 0) || m_wflag);
      check(ovr == m_ovr, "R6 model overrun", ovr, m_ovr);
      check(wake_en == m_wake, "R10 model wake_en", wake_en, m_wake);
      if (mq.size() > 0)
        check({rd_ferr, rd_data} == mq[0], "R2 model head", {rd_ferr, rd_data}, mq[0]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    rx = 1'b0; idle(16 * td);
    for (int i = 0; i < 8; i++) begin rx = b[i]; idle(16 * td); end
    rx = stopv; idle(16 * td);
    rx = 1'b1; idle(4 * td);
  endtask

  task automatic read1();
    rd = 1'b1; idle(1); rd = 1'b0; idle(1);
  endtask

  initial begin
    idle(5); rst_n = 1'b1; run = 1'b1; idle(3);
    check(irq == 0, "R1 irq after reset", irq, 0);
    check(ovr == 0, "R1 overrun after reset", ovr, 0);
    check(wake_en == 0, "R1 wake_en after reset", wake_en, 0);

    send(8'hA5, 1'b1); idle(10);
    check(irq == 1, "R5 irq with word", irq, 1);
    check(rd_data == 8'hA5, "R2 data A5", rd_data, 8'hA5);
    check(rd_ferr == 0, "R4 ferr good stop", rd_ferr, 0);
    read1();
    check(irq == 0, "R5 irq after read", irq, 0);
    read1();
    check(irq == 0, "R5 empty read", irq, 0);

    rx = 1'b0; idle(4); rx = 1'b1; idle(40);
    check(irq == 0, "R3 glitch rejected", irq, 0);
    send(8'h96, 1'b1); idle(10);
    check(rd_data == 8'h96, "R3 after glitch", rd_data, 8'h96);
    read1();

    send(8'h3C, 1'b0); idle(40);
    check(rd_data == 8'h3C, "R4 data with bad stop", rd_data, 8'h3C);
    check(rd_ferr == 1, "R4 ferr set", rd_ferr, 1);
    read1();
    check(irq == 0, "R4 one word only", irq, 0);

    rx_en = 1'b0; send(8'h5A, 1'b1); idle(10);
    check(irq == 0, "R7 disabled no word", irq, 0);
    rx_en = 1'b1; idle(4);

    send(8'h11, 1'b1); send(8'h22, 1'b1); send(8'h33, 1'b1); idle(10);
    check(ovr == 1, "R6 overrun set", ovr, 1);
    check(rd_data == 8'h11, "R6 oldest kept", rd_data, 8'h11);
    send(8'h44, 1'b1); idle(10);
    read1();
    check(rd_data == 8'h22, "R6 second word", rd_data, 8'h22);
    read1();
    check(irq == 0, "R6 third and fourth dropped", irq, 0);
    check(ovr == 1, "R6 overrun held", ovr, 1);
    rx_en = 1'b0; idle(2);
    check(ovr == 0, "R6 overrun cleared", ovr, 0);
    rx_en = 1'b1; idle(4);

    arm = 1'b1; idle(1); arm = 1'b0; idle(3);
    check(wake_en == 1, "R8 wake armed", wake_en, 1);
    check(irq == 0, "R9 no irq before edge", irq, 0);
    rx = 1'b0; idle(60);
    check(irq == 1, "R9 wake irq", irq, 1);
    check(wake_en == 1, "R10 stays armed while low", wake_en, 1);
    idle(100);
    read1();
    check(irq == 0, "R8 no word stored during break", irq, 0);
    idle(60);
    check(irq == 0, "R9 cleared by read", irq, 0);
    rx = 1'b1; idle(8);
    check(wake_en == 0, "R10 disarm on rise", wake_en, 0);
    send(8'h77, 1'b1); idle(10);
    check(rd_data == 8'h77, "R10 normal after wake", rd_data, 8'h77);
    read1();

    td = 3; idle(6);
    send(8'hC3, 1'b1); idle(30);
    check(rd_data == 8'hC3, "R2 slow tick data", rd_data, 8'hC3);
    check(irq == 1, "R5 slow tick irq", irq, 1);
    read1(); idle(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule